// File: doc/BRIEF.md
# Paged register SPI access engine

This block sits between a host that wants to read or write registers of an external switch device and a byte-level SPI shifter. The device's registers are grouped into pages; a register is reached by first selecting its page through a global page register and then addressing it by an offset byte. The host hands the engine one request at a time: write or read, page, offset, a length of one to four bytes and, for writes, the data. The engine turns it into a short series of chip-select framed byte transfers and returns a one-cycle completion with an error flag and the read data.

Every access starts by polling a global status register until the device reports it is not busy. The engine remembers the last page it selected, and sends a page-select transfer only when the requested page differs. Writes go out in one frame. Reads take two phases: a kick-off frame that starts the internal fetch, an acknowledge poll on the same status register, and a fetch frame that reads the bytes from the global data register. Polls are spaced by a programmable number of clock cycles and are abandoned after a programmable count, which ends the request with an error.

Top module: `paged_reg_spi_engine`

## Requirements
- R1: Every frame begins with a command byte (read 0x60, write 0x61) followed by one register-offset byte, and chip select (`spi_cs_n`, active low) stays low for the whole frame and goes high between any two frames.
- R2: Before any page select or access, the engine reads the status register (offset 0xFE) in 3-byte frames (read command, 0xFE, one clocked-in byte) and repeats while bit 7 (busy) of the returned byte is 1; with B busy replies a write request issues exactly B+1 status frames.
- R3: If MAX_POLLS (100) consecutive busy polls all report busy, the request ends with `rsp_err`=1 after exactly MAX_POLLS status frames, and no page-select, write, kick-off or fetch frame is sent.
- R4: Between the end of one poll frame and the start of the next poll of the same wait, chip select stays high for at least POLL_GAP (125) clock cycles.
- R5: The page select is a 3-byte write frame: write command, page-register offset 0xFF, page number. It is sent after the busy poll only when the requested page differs from the cached page, and the cache then takes the new page.
- R6: The cached page is 0xFF after reset, so a first request for page 0xFF sends no page select while any other page does; a request that times out leaves the cache unchanged.
- R7: A write is one frame of write command, offset and N data bytes, N = `req_len_m1`+1, least significant byte first.
- R8: A read sends a kick-off frame (read command, offset, one dummy byte), then polls status until bit 5 (read acknowledge) is 1, then sends one fetch frame: read command, data-register offset 0xF0 and N clocked-in bytes.
- R9: Read data is returned least significant byte first in `rsp_rdata[8N-1:0]`, with the upper bytes zero.
- R10: If MAX_POLLS acknowledge polls all report no acknowledge, the request ends with `rsp_err`=1, no fetch frame is sent and `rsp_rdata` is zero.
- R11: After reset `spi_cs_n` is high, `sb_req` and `rsp_done` are low and `req_ready` is high; `req_ready` is high only while idle, and `rsp_done` is a one-cycle pulse with `rsp_err` and `rsp_rdata` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Register page |
| req_offset | input | 8 | Register offset within the page |
| req_len_m1 | input | 2 | Byte count minus one (0..3 for 1..4 bytes) |
| req_wdata | input | 32 | Write data, byte 0 sent first |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Poll limit reached, valid with rsp_done |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| spi_cs_n | output | 1 | Chip select, low during a frame |
| sb_req | output | 1 | Byte transfer request to the shifter |
| sb_tx | output | 8 | Byte to send, held until acknowledged |
| sb_ack | input | 1 | Shifter pulse: byte exchanged |
| sb_rx | input | 8 | Byte clocked in, valid with sb_ack |

## Verification
The bench models the device side of the shifter, decodes every frame and scripts how many busy and no-acknowledge replies each request meets. It goes after the page cache (a design that never caches sends a page select every time; one that updates the cache on acceptance or on a timed-out request skips a needed select), after byte order and length (a swapped or over-long frame shows up in the decoded write data and in the returned read word), and after the poll limits, where an off-by-one counter issues 99 or 101 status frames and a broken acknowledge timeout would still fetch data. It also measures the chip-select high time between successive polls, which a missing spacing timer would collapse to a single cycle.

// File: rtl/preg_pkg.sv
package preg_pkg;

  typedef enum logic [2:0] {
    FK_BUSYPOLL,
    FK_PAGE,
    FK_WRITE,
    FK_KICK,
    FK_ACKPOLL,
    FK_FETCH
  } frame_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_WAIT,
    ST_RESP
  } eng_state_e;

  typedef struct packed {
    logic        wr;
    logic [7:0]  page;
    logic [7:0]  offset;
    logic [1:0]  len_m1;
    logic [31:0] wdata;
  } host_req_t;

endpackage

// File: rtl/preg_frame_builder.sv
module preg_frame_builder
  import preg_pkg::*;
#(
  parameter logic [7:0] CMD_RD     = 8'h60,
  parameter logic [7:0] CMD_WR     = 8'h61,
  parameter logic [7:0] REG_PAGE   = 8'hFF,
  parameter logic [7:0] REG_STATUS = 8'hFE,
  parameter logic [7:0] REG_DATA0  = 8'hF0
) (
  input  frame_kind_e kind,
  input  logic [2:0]  idx,
  input  host_req_t   req,
  output logic [7:0]  tx_byte,
  output logic [2:0]  last_idx
);

  logic       is_wr;
  logic [7:0] off_byte;
  logic [7:0] data_byte;
  logic [1:0] dsel;

  assign dsel  = idx[1:0] - 2'd2;
  assign is_wr = (kind == FK_PAGE) || (kind == FK_WRITE);

  always_comb begin
    case (kind)
      FK_PAGE:                 off_byte = REG_PAGE;
      FK_WRITE, FK_KICK:       off_byte = req.offset;
      FK_FETCH:                off_byte = REG_DATA0;
      default:                 off_byte = REG_STATUS;
    endcase
  end

  always_comb begin
    case (kind)
      FK_PAGE:  data_byte = req.page;
      FK_WRITE: data_byte = req.wdata[{dsel, 3'b000} +: 8];
      default:  data_byte = 8'h00;
    endcase
  end

  always_comb begin
    if (idx == 3'd0)      tx_byte = is_wr ? CMD_WR : CMD_RD;
    else if (idx == 3'd1) tx_byte = off_byte;
    else                  tx_byte = data_byte;
  end

  always_comb begin
    if ((kind == FK_WRITE) || (kind == FK_FETCH)) last_idx = 3'd2 + {1'b0, req.len_m1};
    else                                          last_idx = 3'd2;
  end

endmodule

// File: rtl/preg_poll_timer.sv
module preg_poll_timer #(
  parameter int MAX_POLLS = 100,
  parameter int POLL_GAP  = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_clr,
  input  logic poll_inc,
  input  logic gap_start,
  output logic limit_hit,
  output logic gap_done
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [CW-1:0] poll_cnt_q, poll_cnt_d;
  logic          poll_en;
  logic [GW-1:0] gap_q, gap_d;
  logic          gap_run_q, gap_run_d;
  logic          gap_en;

  assign limit_hit = (poll_cnt_q >= CW'(MAX_POLLS));
  assign gap_done  = gap_run_q && (gap_q == '0);

  always_comb begin
    poll_en    = poll_clr || (poll_inc && !limit_hit);
    poll_cnt_d = poll_clr ? '0 : poll_cnt_q + 1'b1;
  end

  always_comb begin
    gap_en    = gap_start || gap_run_q;
    gap_d     = gap_q;
    gap_run_d = gap_run_q;
    if (gap_start) begin
      gap_d     = GW'(POLL_GAP - 1);
      gap_run_d = 1'b1;
    end else if (gap_q == '0) begin
      gap_run_d = 1'b0;
    end else begin
      gap_d = gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       poll_cnt_q <= '0;
    else if (poll_en) poll_cnt_q <= poll_cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      gap_run_q <= 1'b0;
    end else if (gap_en) begin
      gap_q     <= gap_d;
      gap_run_q <= gap_run_d;
    end
  end

  assert_poll_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt_q <= CW'(MAX_POLLS));

  assert_gap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done |=> !gap_done);

endmodule

// File: rtl/paged_reg_spi_engine.sv
module paged_reg_spi_engine #(
  parameter logic [7:0] CMD_RD     = 8'h60,
  parameter logic [7:0] CMD_WR     = 8'h61,
  parameter logic [7:0] REG_PAGE   = 8'hFF,
  parameter logic [7:0] REG_STATUS = 8'hFE,
  parameter logic [7:0] REG_DATA0  = 8'hF0,
  parameter int         BUSY_BIT   = 7,
  parameter int         RACK_BIT   = 5,
  parameter int         MAX_POLLS  = 100,
  parameter int         POLL_GAP   = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_offset,
  input  logic [1:0]  req_len_m1,
  input  logic [31:0] req_wdata,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        spi_cs_n,
  output logic        sb_req,
  output logic [7:0]  sb_tx,
  input  logic        sb_ack,
  input  logic [7:0]  sb_rx
);

  import preg_pkg::*;

  localparam logic [7:0] PAGE_AFTER_RESET = 8'hFF;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  eng_state_e  state_q, state_d;
  frame_kind_e fk_q, fk_d;
  logic [2:0]  idx_q, idx_d;
  host_req_t   req_q, req_in;
  logic        req_take;
  logic [7:0]  cache_q;
  logic        cache_ld;
  logic [7:0]  stat_q, stat_d;
  logic [31:0] rdata_q, rdata_d;
  logic        rdata_en;
  logic        err_q, err_d;

  logic        poll_clr, poll_inc, gap_start;
  logic        limit_hit, gap_done;
  logic [2:0]  last_idx;
  logic [1:0]  dsel;
  logic        is_poll;
  frame_kind_e access_kind;

  assign req_in      = '{wr: req_write, page: req_page, offset: req_offset,
                         len_m1: req_len_m1, wdata: req_wdata};
  assign is_poll     = (fk_q == FK_BUSYPOLL) || (fk_q == FK_ACKPOLL);
  assign access_kind = req_q.wr ? FK_WRITE : FK_KICK;
  assign dsel        = idx_q[1:0] - 2'd2;

  preg_frame_builder #(
    .CMD_RD(CMD_RD), .CMD_WR(CMD_WR), .REG_PAGE(REG_PAGE),
    .REG_STATUS(REG_STATUS), .REG_DATA0(REG_DATA0)
  ) u_frame (
    .kind(fk_q), .idx(idx_q), .req(req_q), .tx_byte(sb_tx), .last_idx(last_idx)
  );

  preg_poll_timer #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_timer (
    .clk(clk), .rst_n(rst_ns), .poll_clr(poll_clr), .poll_inc(poll_inc),
    .gap_start(gap_start), .limit_hit(limit_hit), .gap_done(gap_done)
  );

  // next state
  always_comb begin
    state_d   = state_q;
    fk_d      = fk_q;
    idx_d     = idx_q;
    stat_d    = stat_q;
    rdata_d   = rdata_q;
    err_d     = err_q;
    req_take  = 1'b0;
    cache_ld  = 1'b0;
    rdata_en  = 1'b0;
    poll_clr  = 1'b0;
    poll_inc  = 1'b0;
    gap_start = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_take = 1'b1;
          rdata_d  = '0;
          rdata_en = 1'b1;
          err_d    = 1'b0;
          poll_clr = 1'b1;
          fk_d     = FK_BUSYPOLL;
          idx_d    = 3'd0;
          state_d  = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (sb_ack) begin
          if (is_poll && (idx_q == 3'd2)) stat_d = sb_rx;
          if ((fk_q == FK_FETCH) && (idx_q >= 3'd2)) begin
            rdata_d[{dsel, 3'b000} +: 8] = sb_rx;
            rdata_en = 1'b1;
          end
          if (idx_q == last_idx) begin
            state_d  = ST_GAP;
            poll_inc = is_poll;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_GAP: begin
        idx_d = 3'd0;
        case (fk_q)
          FK_BUSYPOLL: begin
            if (!stat_q[BUSY_BIT]) begin
              fk_d    = (req_q.page != cache_q) ? FK_PAGE : access_kind;
              state_d = ST_FRAME;
            end else if (limit_hit) begin
              err_d   = 1'b1;
              state_d = ST_RESP;
            end else begin
              gap_start = 1'b1;
              state_d   = ST_WAIT;
            end
          end
          FK_PAGE: begin
            cache_ld = 1'b1;
            fk_d     = access_kind;
            state_d  = ST_FRAME;
          end
          FK_KICK: begin
            poll_clr = 1'b1;
            fk_d     = FK_ACKPOLL;
            state_d  = ST_FRAME;
          end
          FK_ACKPOLL: begin
            if (stat_q[RACK_BIT]) begin
              fk_d    = FK_FETCH;
              state_d = ST_FRAME;
            end else if (limit_hit) begin
              err_d   = 1'b1;
              state_d = ST_RESP;
            end else begin
              gap_start = 1'b1;
              state_d   = ST_WAIT;
            end
          end
          default: state_d = ST_RESP;
        endcase
      end
      ST_WAIT: begin
        if (gap_done) begin
          idx_d   = 3'd0;
          state_d = ST_FRAME;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      fk_q    <= FK_BUSYPOLL;
      idx_q   <= 3'd0;
      stat_q  <= 8'h00;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fk_q    <= fk_d;
      idx_q   <= idx_d;
      stat_q  <= stat_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       req_q <= '0;
    else if (req_take) req_q <= req_in;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       cache_q <= PAGE_AFTER_RESET;
    else if (cache_ld) cache_q <= req_q.page;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign req_ready = rst_ns && (state_q == ST_IDLE);
  assign spi_cs_n  = (state_q != ST_FRAME);
  assign sb_req    = (state_q == ST_FRAME);
  assign rsp_done  = (state_q == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (sb_req && !sb_ack) |=> (sb_req && $stable(sb_tx)));

  assert_page_before_access_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (sb_req && (idx_q == 3'd0) && ((fk_q == FK_WRITE) || (fk_q == FK_KICK)))
      |-> (cache_q == req_q.page));

  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    ((state_q == ST_WAIT) && !gap_done) |=> spi_cs_n);

  assert_err_no_data_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_done && rsp_err) |-> (rsp_rdata == 32'h0));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_done |=> (!rsp_done && req_ready));

endmodule

// File: tb/paged_reg_spi_engine_tb_top.sv
module paged_reg_spi_engine_tb_top;

  localparam logic [7:0] CMD_RD     = 8'h60;
  localparam logic [7:0] CMD_WR     = 8'h61;
  localparam logic [7:0] REG_PAGE   = 8'hFF;
  localparam logic [7:0] REG_STATUS = 8'hFE;
  localparam logic [7:0] REG_DATA0  = 8'hF0;
  localparam int         MAXP       = 100;
  localparam int         GAP        = 125;

  typedef struct packed {
    logic        wr;
    logic [7:0]  page;
    logic [7:0]  off;
    logic [1:0]  lm1;
    logic [31:0] data;
    logic [7:0]  busy;
    logic [7:0]  rack;
    logic        pg_exp;
    logic [31:0] rd_exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 8'h04, 2'd1, 32'h0000BEEF, 8'd0, 8'd0, 1'b1, 32'h0},
    '{1'b1, 8'h10, 8'h06, 2'd3, 32'h12345678, 8'd2, 8'd0, 1'b0, 32'h0},
    '{1'b0, 8'h10, 8'h08, 2'd0, 32'hA5A5A5C3, 8'd0, 8'd0, 1'b0, 32'h000000C3},
    '{1'b0, 8'h22, 8'h00, 2'd3, 32'hCAFEF00D, 8'd0, 8'd3, 1'b1, 32'hCAFEF00D},
    '{1'b0, 8'h22, 8'h10, 2'd2, 32'h11223344, 8'd1, 8'd1, 1'b0, 32'h00223344},
    '{1'b1, 8'h05, 8'h20, 2'd0, 32'h0000007E, 8'd0, 8'd0, 1'b1, 32'h0},
    '{1'b0, 8'h05, 8'h20, 2'd1, 32'h5555ABCD, 8'd0, 8'd2, 1'b0, 32'h0000ABCD}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_page, req_offset;
  logic [1:0]  req_len_m1;
  logic [31:0] req_wdata;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic        spi_cs_n, sb_req, sb_ack;
  logic [7:0]  sb_tx, sb_rx;

  int n_checks, n_bad;

  // device model state
  int          cyc, hi_cnt, gap_before, fb_n, m_cnt;
  logic        m_busy, cs_q, kicked, prev_status;
  logic [7:0]  fbytes [0:7];
  logic [7:0]  m_rx;
  int          busy_left, rack_left;
  logic [31:0] dev_word;
  int          n_status, n_page, n_write, n_kick, n_fetch, n_frame_bad;
  int          min_poll_gap;
  logic [7:0]  dev_page, wr_off, wr_page;
  int          wr_len;
  logic [31:0] wr_data;
  logic        got_err;
  logic [31:0] got_rdata;

  paged_reg_spi_engine #(
    .CMD_RD(CMD_RD), .CMD_WR(CMD_WR), .REG_PAGE(REG_PAGE), .REG_STATUS(REG_STATUS),
    .REG_DATA0(REG_DATA0), .BUSY_BIT(7), .RACK_BIT(5), .MAX_POLLS(MAXP), .POLL_GAP(GAP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_offset(req_offset),
    .req_len_m1(req_len_m1), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .spi_cs_n(spi_cs_n), .sb_req(sb_req),
    .sb_tx(sb_tx), .sb_ack(sb_ack), .sb_rx(sb_rx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic frame_end();
    logic [31:0] acc;
    logic is_status;
    is_status = 1'b0;
    if (fbytes[0] == CMD_RD && fbytes[1] == REG_STATUS && fb_n == 3) begin
      n_status++;
      is_status = 1'b1;
      if (prev_status && gap_before < min_poll_gap) min_poll_gap = gap_before;
    end else if (fbytes[0] == CMD_WR && fbytes[1] == REG_PAGE && fb_n == 3) begin
      n_page++;
      dev_page = fbytes[2];
    end else if (fbytes[0] == CMD_WR && fb_n >= 3 && fb_n <= 6) begin
      n_write++;
      acc = 32'h0;
      for (int k = 0; k < fb_n - 2; k++) acc[8*k +: 8] = fbytes[2+k];
      wr_data = acc;
      wr_off  = fbytes[1];
      wr_len  = fb_n - 2;
      wr_page = dev_page;
    end else if (fbytes[0] == CMD_RD && fbytes[1] == REG_DATA0 && fb_n >= 3 && fb_n <= 6) begin
      n_fetch++;
      kicked = 1'b0;
    end else if (fbytes[0] == CMD_RD && fb_n == 3) begin
      n_kick++;
      kicked = 1'b1;
    end else begin
      n_frame_bad++;
    end
    prev_status = is_status;
  endtask

  // byte shifter and device model
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      sb_ack <= 1'b0;
      sb_rx  <= 8'h00;
      m_busy = 1'b0;
      m_cnt  = 0;
      fb_n   = 0;
      cs_q   = 1'b1;
      hi_cnt = 0;
    end else begin
      sb_ack <= 1'b0;
      if (cs_q && !spi_cs_n) begin
        gap_before = hi_cnt;
        hi_cnt = 0;
        fb_n = 0;
      end
      if (spi_cs_n) hi_cnt++;
      if (m_busy) begin
        if (m_cnt == 0) begin
          sb_ack <= 1'b1;
          sb_rx  <= m_rx;
          m_busy = 1'b0;
        end else begin
          m_cnt--;
        end
      end else if (sb_req && !sb_ack && fb_n < 8) begin
        fbytes[fb_n] = sb_tx;
        m_rx = 8'hEE;
        if (fb_n >= 2 && fbytes[0] == CMD_RD) begin
          if (fbytes[1] == REG_STATUS) begin
            if (kicked) begin
              m_rx = (rack_left == 0) ? 8'h20 : 8'h00;
              if (rack_left > 0) rack_left--;
            end else begin
              m_rx = (busy_left > 0) ? 8'h80 : 8'h00;
              if (busy_left > 0) busy_left--;
            end
          end else if (fbytes[1] == REG_DATA0 && fb_n <= 5) begin
            m_rx = dev_word[8*(fb_n-2) +: 8];
          end
        end
        fb_n++;
        m_busy = 1'b1;
        m_cnt  = 1;
      end
      if (!cs_q && spi_cs_n) frame_end();
      cs_q = spi_cs_n;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] page, input logic [7:0] off,
                        input logic [1:0] lm1, input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    prev_status = 1'b0;
    kicked      = 1'b0;
    req_valid   = 1'b1;
    req_write   = wr;
    req_page    = page;
    req_offset  = off;
    req_len_m1  = lm1;
    req_wdata   = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    got_err   = rsp_err;
    got_rdata = rsp_rdata;
  endtask

  function automatic logic [31:0] len_mask(input logic [1:0] lm1);
    return (lm1 == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (lm1 + 1))) - 1);
  endfunction

  task automatic check_reset_state(input string tag);
    check(spi_cs_n == 1'b1, tag, {31'h0, spi_cs_n}, 32'h1);
    check(sb_req == 1'b0,   tag, {31'h0, sb_req},   32'h0);
    check(rsp_done == 1'b0, tag, {31'h0, rsp_done}, 32'h0);
    check(req_ready == 1'b1, tag, {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    int s_st, s_pg, s_wr, s_kk, s_ft;
    n_checks = 0; n_bad = 0; cyc = 0;
    n_status = 0; n_page = 0; n_write = 0; n_kick = 0; n_fetch = 0; n_frame_bad = 0;
    min_poll_gap = 1000000; busy_left = 0; rack_left = 0; dev_word = 0;
    dev_page = 8'h00; kicked = 1'b0; prev_status = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_page = 8'h00; req_offset = 8'h00;
    req_len_m1 = 2'd0; req_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("R11 reset state");

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      busy_left = VECS[v].busy;
      rack_left = VECS[v].rack;
      dev_word  = VECS[v].data;
      s_st = n_status; s_pg = n_page; s_wr = n_write; s_kk = n_kick; s_ft = n_fetch;
      do_req(VECS[v].wr, VECS[v].page, VECS[v].off, VECS[v].lm1, VECS[v].data);
      check(got_err == 1'b0, "R11 no error", {31'h0, got_err}, 32'h0);
      check((n_page - s_pg) == int'(VECS[v].pg_exp), "R5 page select count",
            n_page - s_pg, {31'h0, VECS[v].pg_exp});
      if (VECS[v].wr) begin
        check((n_status - s_st) == VECS[v].busy + 1, "R2 busy polls",
              n_status - s_st, VECS[v].busy + 1);
        check(wr_data == (VECS[v].data & len_mask(VECS[v].lm1)), "R7 write data LSB first",
              wr_data, VECS[v].data & len_mask(VECS[v].lm1));
        check(wr_len == VECS[v].lm1 + 1 && wr_off == VECS[v].off && wr_page == VECS[v].page,
              "R7 write length/offset/page", {wr_page, wr_off, 8'h0, 8'(wr_len)},
              {VECS[v].page, VECS[v].off, 8'h0, 8'(VECS[v].lm1 + 1)});
      end else begin
        check((n_status - s_st) == VECS[v].busy + VECS[v].rack + 2, "R8 busy+ack polls",
              n_status - s_st, VECS[v].busy + VECS[v].rack + 2);
        check((n_kick - s_kk) == 1 && (n_fetch - s_ft) == 1 && n_write == s_wr,
              "R8 kick and fetch frames", {16'(n_kick - s_kk), 16'(n_fetch - s_ft)},
              {16'd1, 16'd1});
        check(got_rdata == VECS[v].rd_exp, "R9 read data", got_rdata, VECS[v].rd_exp);
      end
    end

    // poll spacing
    check(min_poll_gap >= GAP && min_poll_gap < 1000000, "R4 poll spacing",
          min_poll_gap, GAP);

    // busy timeout: page 0x33 must not enter the cache
    busy_left = 250; rack_left = 0;
    s_st = n_status; s_pg = n_page; s_wr = n_write; s_kk = n_kick; s_ft = n_fetch;
    do_req(1'b0, 8'h33, 8'h02, 2'd3, 32'h0);
    check(got_err == 1'b1, "R3 busy timeout error", {31'h0, got_err}, 32'h1);
    check((n_status - s_st) == MAXP, "R3 poll count at timeout", n_status - s_st, MAXP);
    check(n_page == s_pg && n_kick == s_kk && n_write == s_wr && n_fetch == s_ft,
          "R3 no frames after timeout", n_page - s_pg + n_kick - s_kk, 0);
    busy_left = 0;
    s_pg = n_page;
    do_req(1'b1, 8'h33, 8'h30, 2'd0, 32'h5A);
    check((n_page - s_pg) == 1, "R6 cache unchanged by timeout", n_page - s_pg, 1);

    // acknowledge timeout
    rack_left = 250; dev_word = 32'hDEADBEEF;
    s_st = n_status; s_ft = n_fetch; s_kk = n_kick;
    do_req(1'b0, 8'h33, 8'h40, 2'd3, 32'h0);
    check(got_err == 1'b1, "R10 ack timeout error", {31'h0, got_err}, 32'h1);
    check(n_fetch == s_ft && (n_kick - s_kk) == 1, "R10 no fetch frame", n_fetch - s_ft, 0);
    check(got_rdata == 32'h0, "R10 read data zero", got_rdata, 32'h0);
    check((n_status - s_st) == MAXP + 1, "R10 ack poll count", n_status - s_st, MAXP + 1);
    rack_left = 0;

    // reset clears the cache to 0xFF
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b0 && spi_cs_n == 1'b1, "R11 state in reset",
          {30'h0, req_ready, spi_cs_n}, 32'h1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("R11 reset state after rerun");
    s_pg = n_page;
    do_req(1'b1, 8'hFF, 8'h01, 2'd0, 32'h11);
    check(n_page == s_pg, "R6 page 0xFF skipped after reset", n_page - s_pg, 0);
    s_pg = n_page;
    do_req(1'b1, 8'h00, 8'h01, 2'd0, 32'h22);
    check((n_page - s_pg) == 1 && dev_page == 8'h00, "R6 page 0x00 selected after reset",
          {24'h0, dev_page}, 32'h0);

    check(n_frame_bad == 0, "R1 frame format", n_frame_bad, 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL R11 watchdog expired actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule